// File: doc/BRIEF.md
# Fractional-Period Tick Generator

This block divides a fast system clock into a slower tick train. With the defaults, a 100 MHz clock (10 ns timebase) gives a 1 MHz tick. A plain integer divider can only reach frequencies that are whole divisions of the clock. This block gets much finer average resolution by stretching or shrinking a programmed number of output periods by exactly one clock. It does this once in every frame of many periods. With a 100-clock nominal period and a 100,000-period frame (100 ms), one shortened period per frame raises the mean rate by about 0.1 Hz, or 0.1 ppm. The correction can reach ±200 ppm, so the block suits slow digital frequency trimming, for example as the output stage of a digital phase-locked loop.

The correction word is signed. A positive value shortens that many periods at the start of the frame to one clock below nominal. A negative value lengthens that many periods to one clock above nominal. The magnitude is clamped to a parameter limit. The word is sampled on the first clock of each frame, so software or a loop filter can change it at any time, and the change takes effect at the next frame. The correction is a level-type control input with no handshake, and the outputs are free-running strobes and a square wave. The block has no valid/ready interface and never applies back-pressure.

Outputs are a one-clock tick at the end of each period, a square wave that is high for the first half of each period, and a frame strobe that marks the last period of a frame.

Top module: `frac_tick_gen`

## Requirements
- R1: While `rst` is high, `tick_o` and `frame_o` are low. After `rst` falls, the first period starts at count zero of frame period zero.
- R2: With a correction of 0, every period lasts NOM_DIV clocks.
- R3: With a correction N > 0, periods 0 to N-1 of the frame last NOM_DIV-1 clocks, and the rest of the periods last NOM_DIV clocks.
- R4: With a correction N < 0, periods 0 to |N|-1 of the frame last NOM_DIV+1 clocks, and the rest of the periods last NOM_DIV clocks.
- R5: A correction above +CORR_LIMIT acts as +CORR_LIMIT, and one below -CORR_LIMIT acts as -CORR_LIMIT.
- R6: The correction is sampled only on the first clock of a frame. A change later in the frame has no effect until the next frame.
- R7: `tick_o` is high for exactly one clock, the last clock of each period.
- R8: `sq_o` is high for the first floor(L/2) clocks of a period of length L and low for the rest of that period.
- R9: `frame_o` is high only together with the tick that ends period FRAME_LEN-1, the last period of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| corr_in | input | CORR_W | Signed correction, in periods per frame (+ shortens, - lengthens) |
| tick_o | output | 1 | One-clock strobe at the end of each period |
| sq_o | output | 1 | Square wave, high for the first half of each period |
| frame_o | output | 1 | One-clock strobe with the tick that ends a frame |

## Verification
The hardest case to reach is a correction that changes partway through a frame. The change must be ignored for the rest of that frame and take effect exactly at the next frame boundary. The bench follows each frame period by period, counting clocks between ticks. It switches the correction at the start of a period whose length would differ under the new value. It then checks that this period keeps its old length and that the next frame follows the new value. The frame is shortened through parameters so that many whole frames, including clamped extremes, fit into a short run.

// File: rtl/frac_tick_pkg.sv
package frac_tick_pkg;
  typedef enum logic [1:0] {
    PER_NOM   = 2'd0,
    PER_SHORT = 2'd1,
    PER_LONG  = 2'd2
  } per_kind_e;
endpackage

// File: rtl/ftg_corr_latch.sv
module ftg_corr_latch #(
  parameter int CORR_W     = 12,
  parameter int CORR_LIMIT = 2000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frame_end,
  input  logic signed [CORR_W-1:0] corr_in,
  output logic                     armed,
  output logic signed [CORR_W-1:0] corr_q,
  output logic        [CORR_W-1:0] mag,
  output logic                     neg
);
  localparam logic signed [CORR_W-1:0] POS_LIM = CORR_W'(CORR_LIMIT);
  localparam logic signed [CORR_W-1:0] NEG_LIM = -POS_LIM;

  logic signed [CORR_W-1:0] clamped;
  logic signed [CORR_W-1:0] eff;

  always_comb begin
    if (corr_in > POS_LIM)      clamped = POS_LIM;
    else if (corr_in < NEG_LIM) clamped = NEG_LIM;
    else                        clamped = corr_in;
  end

  // first clock of a frame uses the live value; later clocks use the held copy
  assign eff = armed ? clamped : corr_q;
  assign neg = eff[CORR_W-1];
  assign mag = neg ? CORR_W'(-eff) : CORR_W'(eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b1;
      corr_q <= '0;
    end else begin
      armed <= frame_end;
      if (armed) corr_q <= clamped;
    end
  end
endmodule

// File: rtl/ftg_frame_ctr.sv
module ftg_frame_ctr
  import frac_tick_pkg::*;
#(
  parameter int FRAME_LEN = 100000,
  parameter int CORR_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CORR_W-1:0] mag,
  input  logic              neg,
  output per_kind_e         kind,
  output logic              frame_end
);
  localparam int FRM_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [FRM_W-1:0] LAST = FRM_W'(FRAME_LEN - 1);

  logic [FRM_W-1:0] idx;

  always_comb begin
    if (32'(idx) < 32'(mag)) kind = neg ? PER_LONG : PER_SHORT;
    else                     kind = PER_NOM;
  end

  assign frame_end = tick && (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst)            idx <= '0;
    else if (frame_end) idx <= '0;
    else if (tick)      idx <= idx + 1'b1;
  end
endmodule

// File: rtl/ftg_period_ctr.sv
module ftg_period_ctr
  import frac_tick_pkg::*;
#(
  parameter int NOM_DIV = 100
) (
  input  logic      clk,
  input  logic      rst,
  input  per_kind_e kind,
  output logic      tick,
  output logic      sq
);
  localparam int CNT_W = $clog2(NOM_DIV + 2);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len;

  always_comb begin
    unique case (kind)
      PER_SHORT: len = CNT_W'(NOM_DIV - 1);
      PER_LONG:  len = CNT_W'(NOM_DIV + 1);
      default:   len = CNT_W'(NOM_DIV);
    endcase
  end

  assign tick = (cnt == len - 1'b1);
  assign sq   = (cnt < (len >> 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
  import frac_tick_pkg::*;
#(
  parameter int NOM_DIV    = 100,
  parameter int FRAME_LEN  = 100000,
  parameter int CORR_W     = 12,
  parameter int CORR_LIMIT = 2000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [CORR_W-1:0] corr_in,
  output logic                     tick_o,
  output logic                     sq_o,
  output logic                     frame_o
);
  logic                     armed_w;
  logic signed [CORR_W-1:0] corr_q_w;
  logic        [CORR_W-1:0] mag_w;
  logic                     neg_w;
  logic                     tick_w;
  logic                     fend_w;
  per_kind_e                kind_w;

  ftg_corr_latch #(.CORR_W(CORR_W), .CORR_LIMIT(CORR_LIMIT)) u_latch (
    .clk(clk), .rst(rst), .frame_end(fend_w), .corr_in(corr_in),
    .armed(armed_w), .corr_q(corr_q_w), .mag(mag_w), .neg(neg_w)
  );

  ftg_frame_ctr #(.FRAME_LEN(FRAME_LEN), .CORR_W(CORR_W)) u_frame (
    .clk(clk), .rst(rst), .tick(tick_w), .mag(mag_w), .neg(neg_w),
    .kind(kind_w), .frame_end(fend_w)
  );

  ftg_period_ctr #(.NOM_DIV(NOM_DIV)) u_period (
    .clk(clk), .rst(rst), .kind(kind_w), .tick(tick_w), .sq(sq_o)
  );

  assign tick_o  = tick_w;
  assign frame_o = fend_w;
endmodule

// File: rtl/ftg_checker.sv
module ftg_checker #(
  parameter int CORR_W     = 12,
  parameter int CORR_LIMIT = 2000
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     tick_o,
  input logic                     sq_o,
  input logic                     frame_o,
  input logic                     armed,
  input logic signed [CORR_W-1:0] corr_q
);
  // R9
  frame_with_tick_chk: assert property (@(posedge clk) disable iff (rst)
    frame_o |-> tick_o);

  // R7
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  // R8
  sq_low_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> !sq_o);

  // R8
  sq_high_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> sq_o);

  // R6
  corr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |=> $stable(corr_q));

  // R5
  corr_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (corr_q <= CORR_W'(CORR_LIMIT)) && (corr_q >= -CORR_W'(CORR_LIMIT)));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |-> (!tick_o && !frame_o));
endmodule

bind frac_tick_gen ftg_checker #(.CORR_W(CORR_W), .CORR_LIMIT(CORR_LIMIT)) u_chk (
  .clk(clk), .rst(rst), .tick_o(tick_o), .sq_o(sq_o), .frame_o(frame_o),
  .armed(armed_w), .corr_q(corr_q_w)
);

// File: tb/tb_frac_tick_gen.sv
module tb_frac_tick_gen;
  localparam int NOM = 10;
  localparam int FL  = 8;
  localparam int CW  = 6;
  localparam int LIM = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [CW-1:0] corr_in = '0;
  logic tick_o, sq_o, frame_o;

  int vectors = 0;
  int fails   = 0;

  frac_tick_gen #(.NOM_DIV(NOM), .FRAME_LEN(FL), .CORR_W(CW), .CORR_LIMIT(LIM)) dut (
    .clk(clk), .rst(rst), .corr_in(corr_in),
    .tick_o(tick_o), .sq_o(sq_o), .frame_o(frame_o)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(input int n, input int k);
    int c = n;
    int m;
    if (c > LIM) c = LIM;
    if (c < -LIM) c = -LIM;
    m = (c < 0) ? -c : c;
    if (k < m) return (c > 0) ? NOM - 1 : NOM + 1;
    return NOM;
  endfunction

  // Follows one frame; corr is switched at the start of period chg_at when chg_at >= 0
  task automatic run_frame(input string req, input int drive, input int exp_n,
                           input int chg_at, input int chg_to);
    corr_in = CW'(drive);
    for (int k = 0; k < FL; k++) begin
      int len = 0;
      int hi = 0;
      bit done = 0;
      while (!done && len < 4 * NOM) begin
        @(negedge clk); #1;
        if (k == chg_at && len == 0) corr_in = CW'(chg_to);
        len++;
        if (sq_o) hi++;
        if (tick_o) begin
          done = 1;
          check("R9", $sformatf("frame strobe at period %0d", k), int'(frame_o), (k == FL-1) ? 1 : 0);
        end
      end
      check(req, $sformatf("period %0d length", k), len, exp_len(exp_n, k));
      check("R8", $sformatf("period %0d high clocks", k), hi, exp_len(exp_n, k) / 2);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      check("R1", "tick in reset", int'(tick_o), 0);
      check("R1", "frame in reset", int'(frame_o), 0);
    end
    @(posedge clk); #1;
    rst = 1'b0;
  endtask

  task automatic test_nominal();
    do_reset();
    run_frame("R2", 0, 0, -1, 0);
    run_frame("R2", 0, 0, -1, 0);
  endtask

  task automatic test_shorten();
    run_frame("R3", 3, 3, -1, 0);
    run_frame("R3", 1, 1, -1, 0);
  endtask

  task automatic test_lengthen();
    run_frame("R4", -2, -2, -1, 0);
    run_frame("R4", -4, -4, -1, 0);
  endtask

  task automatic test_clamp();
    run_frame("R5", 20, 20, -1, 0);
    run_frame("R5", -32, -32, -1, 0);
  endtask

  task automatic test_midframe();
    run_frame("R6", 3, 3, 2, -4);
    run_frame("R6", -4, -4, -1, 0);
  endtask

  task automatic test_reset_midframe();
    corr_in = CW'(2);
    repeat (23) @(negedge clk);
    corr_in = '0;
    do_reset();
    run_frame("R1", 0, 0, -1, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    test_nominal();
    test_shorten();
    test_lengthen();
    test_clamp();
    test_midframe();
    test_reset_midframe();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule